// File: doc/BRIEF.md
# Oversampling Converter Timing Controller

This block derives every timing enable of a two-stage decimating sigma-delta converter from a single master clock. It produces a modulator sample enable, a strobe for each output of the first decimation stage (ratio 16) and of the final stage (ratio 4), a serial bit-clock enable and a frame-start pulse. All of these are single-cycle enables in the master-clock domain. One mode input selects whether the converter delivers words from the final filter or straight from the first-stage filter. The mode changes the bit rate and the frame length.

All enables come from one free-running phase counter. Its length is one final-stage output period (128 master cycles). The mode input only changes which counter phases are decoded, so a mode change never moves the timing grid.

An optional external sync input lets several converters on a common clock run in lock-step. The input is sampled on the falling master-clock edge. A rising edge counts only after the input has been seen low on at least two consecutive falling edges. A qualified rise clears the whole divider chain, so the next frame starts from that point. When the sync input is left low, frames are generated internally.

Top module: `tconv_timing`

## Requirements
- R1: While `rstN` is low, all five enables are low. After release, the first rising clock edge starts the timing. `frameStart` is high in the master-clock cycle that follows that edge.
- R2: `modStrobe` is high for one cycle in every second master cycle, in both modes. Over 128 cycles it is high exactly 64 times.
- R3: `stage1Strobe` is high once every 32 master cycles, which is 16 modulator samples. `stage2Strobe` is high once every 128 master cycles when `firstStage` = 0. It is never high when `firstStage` = 1.
- R4: `bitStrobe` is high once every 4 master cycles when `firstStage` = 0 (final-filter mode). It is high once every 2 master cycles when `firstStage` = 1 (first-stage mode).
- R5: `frameStart` repeats every 128 master cycles in final-filter mode, which is 32 bit periods. It repeats every 32 master cycles in first-stage mode, which is 16 bit periods. Every `frameStart` coincides with `bitStrobe` and `stage1Strobe`.
- R6: A change of `firstStage` does not re-phase the counters. First-stage frames fall on every 32nd cycle of the existing 128-cycle grid.
- R7: `syncIn` is sampled on the falling clock edge. Suppose it is seen high after at least 2 consecutive low samples. Then the next rising edge clears all dividers, and `frameStart` is high in the cycle after that edge. A rise driven just after rising edge n therefore gives `frameStart` in cycle n+1.
- R8: A rise of `syncIn` preceded by fewer than 2 low falling-edge samples is ignored. The frame grid continues unchanged.
- R9: A single qualified rise realigns the timing once, even if `syncIn` stays high afterwards. While `syncIn` stays low, frames keep coming at the internal rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | External frame sync, sampled on the falling edge |
| firstStage | input | 1 | 1 = first-stage filter output mode, 0 = final-filter mode |
| modStrobe | output | 1 | Modulator sample enable |
| stage1Strobe | output | 1 | First decimator output enable |
| stage2Strobe | output | 1 | Final decimator output enable |
| bitStrobe | output | 1 | Serial bit-clock enable |
| frameStart | output | 1 | First cycle of an output word frame |

## Verification
The bench predicts the cycle of every frame start for each window and compares it with the observed one.

- A design that re-phased on a mode change would put first-stage frames off the 32-cycle grid.
- A design that honoured a sync after only one low sample would shift the grid in the short-pulse window.
- A design that ignored a qualified sync, or counted from the wrong edge, would produce a frame from the old grid, or a frame one cycle late.

Enable counts per window catch wrong divider ratios in each mode, including a final-stage strobe that leaks into first-stage mode.

// File: rtl/tconv_pkg.sv
`timescale 1ns/1ps
package tconv_pkg;

  // control -> datapath
  typedef struct packed {
    logic run;      // counting enabled (set after reset release)
    logic realign;  // qualified sync: clear the divider chain
  } tconvCtrl_t;

  // datapath -> top
  typedef struct packed {
    logic modStrobe;
    logic stage1Strobe;
    logic stage2Strobe;
    logic bitStrobe;
    logic frameStart;
  } tconvStrobe_t;

endpackage

// File: rtl/tconv_ctrl.sv
`timescale 1ns/1ps
module tconv_ctrl
  import tconv_pkg::*;
#(
  parameter int SYNC_LOW_MIN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  output tconvCtrl_t ctrl
);

  localparam int LW = $clog2(SYNC_LOW_MIN + 1);
  localparam logic [LW-1:0] LOW_MIN = LW'(SYNC_LOW_MIN);

  logic [LW-1:0] lowCnt;
  logic          syncHit;
  logic          run;

  // falling-edge sampling of the sync input with low-period qualification
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      syncHit <= 1'b0;
    end else if (!syncIn) begin
      syncHit <= 1'b0;
      if (lowCnt != LOW_MIN) lowCnt <= lowCnt + 1'b1;
    end else begin
      syncHit <= (lowCnt == LOW_MIN);
      lowCnt  <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) run <= 1'b0;
    else       run <= 1'b1;
  end

  assign ctrl.run     = run;
  assign ctrl.realign = syncHit;

  // R9
  single_realign_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.realign |=> !ctrl.realign);

  // R7
  realign_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.realign |-> ctrl.run);

endmodule

// File: rtl/tconv_datapath.sv
`timescale 1ns/1ps
module tconv_datapath
  import tconv_pkg::*;
#(
  parameter int MOD_DIV       = 2,
  parameter int STAGE1_RATIO  = 16,
  parameter int STAGE2_RATIO  = 4,
  parameter int BIT_DIV_FINAL = 4,
  parameter int BIT_DIV_FIRST = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         firstStage,
  input  tconvCtrl_t   ctrl,
  output tconvStrobe_t strb
);

  // all periods are powers of two: phases decode with masks
  localparam int S1_PERIOD   = MOD_DIV * STAGE1_RATIO;
  localparam int FRAME_FINAL = S1_PERIOD * STAGE2_RATIO;
  localparam int CW          = $clog2(FRAME_FINAL);

  localparam logic [CW-1:0] LAST       = CW'(FRAME_FINAL - 1);
  localparam logic [CW-1:0] MOD_MASK   = CW'(MOD_DIV - 1);
  localparam logic [CW-1:0] S1_MASK    = CW'(S1_PERIOD - 1);
  localparam logic [CW-1:0] S2_MASK    = CW'(FRAME_FINAL - 1);
  localparam logic [CW-1:0] BFIN_MASK  = CW'(BIT_DIV_FINAL - 1);
  localparam logic [CW-1:0] BFST_MASK  = CW'(BIT_DIV_FIRST - 1);

  logic [CW-1:0] phase;
  logic [CW-1:0] bitMask;
  logic [CW-1:0] frameMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             phase <= '0;
    else if (ctrl.realign) phase <= '0;
    else if (ctrl.run)     phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  always_comb begin
    bitMask   = firstStage ? BFST_MASK : BFIN_MASK;
    frameMask = firstStage ? S1_MASK   : S2_MASK;

    strb.modStrobe    = ctrl.run && ((phase & MOD_MASK) == '0);
    strb.stage1Strobe = ctrl.run && ((phase & S1_MASK) == '0);
    strb.stage2Strobe = ctrl.run && !firstStage && ((phase & S2_MASK) == '0);
    strb.bitStrobe    = ctrl.run && ((phase & bitMask) == '0);
    strb.frameStart   = ctrl.run && ((phase & frameMask) == '0);
  end

  // R7
  sync_realign_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.realign |=> strb.frameStart);

  // R2
  mod_alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.modStrobe && !ctrl.realign) |=> !strb.modStrobe);

  // R5
  frame_on_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |-> (strb.bitStrobe && strb.stage1Strobe));

  // R3
  stage2_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stage2Strobe |-> !firstStage);

endmodule

// File: rtl/tconv_timing.sv
`timescale 1ns/1ps
module tconv_timing
  import tconv_pkg::*;
#(
  parameter int MOD_DIV       = 2,
  parameter int STAGE1_RATIO  = 16,
  parameter int STAGE2_RATIO  = 4,
  parameter int BIT_DIV_FINAL = 4,
  parameter int BIT_DIV_FIRST = 2,
  parameter int SYNC_LOW_MIN  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  input  logic firstStage,
  output logic modStrobe,
  output logic stage1Strobe,
  output logic stage2Strobe,
  output logic bitStrobe,
  output logic frameStart
);

  tconvCtrl_t   ctrlBus;
  tconvStrobe_t strb;

  tconv_ctrl #(.SYNC_LOW_MIN(SYNC_LOW_MIN)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .ctrl   (ctrlBus)
  );

  tconv_datapath #(
    .MOD_DIV       (MOD_DIV),
    .STAGE1_RATIO  (STAGE1_RATIO),
    .STAGE2_RATIO  (STAGE2_RATIO),
    .BIT_DIV_FINAL (BIT_DIV_FINAL),
    .BIT_DIV_FIRST (BIT_DIV_FIRST)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .firstStage (firstStage),
    .ctrl       (ctrlBus),
    .strb       (strb)
  );

  assign modStrobe    = strb.modStrobe;
  assign stage1Strobe = strb.stage1Strobe;
  assign stage2Strobe = strb.stage2Strobe;
  assign bitStrobe    = strb.bitStrobe;
  assign frameStart   = strb.frameStart;

endmodule

// File: tb/tconv_timing_bench.sv
`timescale 1ns/1ps
module tconv_timing_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0;
  logic firstStage = 1'b0;
  logic modStrobe, stage1Strobe, stage2Strobe, bitStrobe, frameStart;

  tconv_timing u_tconv_timing (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .firstStage(firstStage),
    .modStrobe(modStrobe), .stage1Strobe(stage1Strobe),
    .stage2Strobe(stage2Strobe), .bitStrobe(bitStrobe),
    .frameStart(frameStart)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    errors = 0;
  int    expQ[$];
  int    winLo = 0;
  int    winHi = 0;
  string winTag = "";
  int    nMod, nBit, nS1, nS2;
  bit    finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic goTo(input int t);
    while (cyc < t) begin
      @(posedge clk);
      #1;
    end
  endtask

  // driver side of the scoreboard
  task automatic openWindow(input int lo, input int hi, input string tag);
    expQ.delete();
    winLo = lo; winHi = hi; winTag = tag;
    nMod = 0; nBit = 0; nS1 = 0; nS2 = 0;
  endtask

  task automatic pushFrames(input int first, input int period, input int hi);
    for (int t = first; t < hi; t += period) expQ.push_back(t);
  endtask

  task automatic closeWindow();
    goTo(winHi);
    check(expQ.size() == 0, {winTag, " missing frameStart"}, expQ.size(), 0);
  endtask

  // monitor side: samples 4 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (cyc >= winLo && cyc < winHi) begin
        if (modStrobe)    nMod++;
        if (bitStrobe)    nBit++;
        if (stage1Strobe) nS1++;
        if (stage2Strobe) nS2++;
        if (frameStart) begin
          if (expQ.size() == 0) begin
            check(1'b0, {winTag, " unexpected frameStart"}, cyc, -1);
          end else begin
            int e;
            e = expQ.pop_front();
            check(cyc == e, {winTag, " frameStart cycle"}, cyc, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, lo, n, base2, m, first, m2, base3;

    // R1 reset state
    repeat (3) @(posedge clk);
    #4;
    check(modStrobe == 1'b0,    "R1 modStrobe in reset",    modStrobe, 0);
    check(stage1Strobe == 1'b0, "R1 stage1Strobe in reset", stage1Strobe, 0);
    check(stage2Strobe == 1'b0, "R1 stage2Strobe in reset", stage2Strobe, 0);
    check(bitStrobe == 1'b0,    "R1 bitStrobe in reset",    bitStrobe, 0);
    check(frameStart == 1'b0,   "R1 frameStart in reset",   frameStart, 0);

    @(posedge clk);
    #1;
    rstN = 1'b1;
    base = cyc + 1;

    // R1 R5 R9: free-running final-filter frames, sync held low
    openWindow(base, base + 256, "R1/R5/R9 final");
    pushFrames(base, 128, base + 256);
    closeWindow();
    check(nMod == 128, "R2 mod count final", nMod, 128);
    check(nBit == 64,  "R4 bit count final", nBit, 64);
    check(nS1 == 8,    "R3 stage1 count final", nS1, 8);
    check(nS2 == 2,    "R3 stage2 count final", nS2, 2);

    // R6 mode change keeps the grid; R3 R4 first-stage rates
    lo = base + 512;
    goTo(lo - 10);
    firstStage = 1'b1;
    openWindow(lo, lo + 128, "R6 first-stage");
    pushFrames(lo, 32, lo + 128);
    closeWindow();
    check(nMod == 64, "R2 mod count first-stage", nMod, 64);
    check(nBit == 64, "R4 bit count first-stage", nBit, 64);
    check(nS1 == 4,   "R3 stage1 count first-stage", nS1, 4);
    check(nS2 == 0,   "R3 stage2 absent first-stage", nS2, 0);
    firstStage = 1'b0;

    // R7 qualified sync realigns; R9 held high does not retrigger
    n = base + 713;
    base2 = n + 1;
    openWindow(base2, base2 + 256, "R7/R9 sync");
    pushFrames(base2, 128, base2 + 256);
    goTo(n);
    syncIn = 1'b1;
    closeWindow();
    check(nBit == 64, "R7 bit count after sync", nBit, 64);

    // R8 short low pulse is ignored
    m = base2 + 300;
    goTo(m);
    syncIn = 1'b0;
    openWindow(m, m + 256, "R8 short sync");
    first = base2 + ((m - base2 + 127) / 128) * 128;
    pushFrames(first, 128, m + 256);
    goTo(m + 1);
    syncIn = 1'b1;
    closeWindow();
    check(nS2 == 2, "R8 stage2 count unchanged", nS2, 2);

    // R7 two-cycle low then rise, in first-stage mode
    m2 = m + 300;
    goTo(m2);
    syncIn = 1'b0;
    firstStage = 1'b1;
    base3 = m2 + 3;
    openWindow(base3, base3 + 128, "R7 sync first-stage");
    pushFrames(base3, 32, base3 + 128);
    goTo(m2 + 2);
    syncIn = 1'b1;
    closeWindow();
    check(nS2 == 0,   "R3 stage2 absent after sync", nS2, 0);
    check(nBit == 64, "R4 bit count after sync first-stage", nBit, 64);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule